// File: doc/BRIEF.md
# Masked Vector Operand Access Unit

This unit sits between a SIMD execution pipeline and a banked vector register file of 32-bit registers. It serves one source operand read and one destination operand write per wavefront of 64 lanes. An operand is either one dword or two dwords per lane. A two-dword operand occupies two consecutive register indices: the first register carries the low half of each lane and the second carries the high half.

On the read side, the unit issues the register indices to the file and receives one full register per port on the following cycle. It then assembles a 64-bit value for every lane. Optional floating-point absolute-value and negate modifiers are applied to that value. When the source is a scalar rather than a vector register, the supplied scalar value is broadcast to every lane and the same modifiers are applied to it.

On the write side, the unit splits each lane's value into halves and drives the register file write ports. The write ports carry a per-lane enable. That enable comes from one of three places: the wavefront's live execute mask, the mask captured with a load instruction, or all lanes when an override input is set. Register renaming and the storage itself lie outside the unit.

Top module: `vop_access_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_valid`, `rf_wr_en0` and `rf_wr_en1` are 0.
- R2: A vector read with `rd_wide`=0 drives `rf_rd_en0`=1 and `rf_rd_addr0`=`rd_base` in the request cycle. Two clock edges after the request, `res_valid`=1. Lane i of `res_data` (bits 64i+63:64i) then holds lane i of that register (bits 32i+31:32i of `rf_rd_data0`) in its low 32 bits and zero in its high 32 bits.
- R3: A vector read with `rd_wide`=1 also drives `rf_rd_en1`=1 and `rf_rd_addr1`=`rd_base`+1. Lane i of the result holds the lane-i word from register `rd_base` in bits 31:0 and the lane-i word from register `rd_base`+1 in bits 63:32.
- R4: A read with `rd_from_vec`=0 returns the value of `rd_scalar` in every lane. For a narrow read that value is bits 31:0 with the high half zero; for a wide read it is all 64 bits. The register file contents have no effect on the result.
- R5: With `rd_abs`=1 and `rd_neg`=0, the sign bit of each lane result is 0, and every other bit is unchanged. The sign bit is bit 31 for a narrow operand and bit 63 for a wide one.
- R6: With `rd_neg`=1 the sign bit is inverted after the absolute step. With both modifiers set, every lane's sign bit is therefore 1.
- R7: The modifiers of R5 and R6 act identically on a broadcast scalar source.
- R8: A write request drives `rf_wr_en0`=1 on the next cycle. At that point `rf_wr_addr0`=`wr_base`, and lane i of `rf_wr_data0` holds bits 31:0 of lane i of `wr_data`.
- R9: A wide write also drives, in that same cycle, `rf_wr_en1`=1, `rf_wr_addr1`=`wr_base`+1, and lane i of `rf_wr_data1` equal to bits 63:32 of lane i of `wr_data`. A narrow write leaves `rf_wr_en1`=0.
- R10: When `wr_ignore_exec`=0, `rf_wr_lane_en` equals `wr_inst_mask` for a write with `wr_is_load`=1, and equals `wave_exec_mask` otherwise (bit i enables lane i).
- R11: When `wr_ignore_exec`=1, all bits of `rf_wr_lane_en` are 1, whatever either mask holds.
- R12: A lane whose enable bit is 0 keeps both halves of its register contents. A later read of those registers returns the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | Source operand read request |
| rd_from_vec | input | 1 | 1: source is a vector register, 0: broadcast scalar |
| rd_wide | input | 1 | 1: two-dword operand |
| rd_abs | input | 1 | Absolute-value modifier |
| rd_neg | input | 1 | Negate modifier |
| rd_base | input | IDX_W | First register index of the source |
| rd_scalar | input | 64 | Scalar source value |
| rf_rd_en0 | output | 1 | Read enable, low-half register |
| rf_rd_en1 | output | 1 | Read enable, high-half register |
| rf_rd_addr0 | output | IDX_W | Low-half register index |
| rf_rd_addr1 | output | IDX_W | High-half register index |
| rf_rd_data0 | input | LANES*32 | Low-half register data, one cycle after enable |
| rf_rd_data1 | input | LANES*32 | High-half register data, one cycle after enable |
| res_valid | output | 1 | Source result valid |
| res_data | output | LANES*64 | Per-lane source result |
| wr_valid | input | 1 | Destination operand write request |
| wr_wide | input | 1 | 1: two-dword operand |
| wr_is_load | input | 1 | Write belongs to a load instruction |
| wr_ignore_exec | input | 1 | Force every lane enabled |
| wr_base | input | IDX_W | First register index of the destination |
| wr_inst_mask | input | LANES | Mask captured with a load |
| wave_exec_mask | input | LANES | Wavefront's live execute mask |
| wr_data | input | LANES*64 | Per-lane destination value |
| rf_wr_en0 | output | 1 | Write enable, low-half register |
| rf_wr_en1 | output | 1 | Write enable, high-half register |
| rf_wr_addr0 | output | IDX_W | Low-half register index |
| rf_wr_addr1 | output | IDX_W | High-half register index |
| rf_wr_lane_en | output | LANES | Per-lane write enable |
| rf_wr_data0 | output | LANES*32 | Low-half write data |
| rf_wr_data1 | output | LANES*32 | High-half write data |

## Verification
Several properties are checked on every cycle: the pipeline timing of reads and writes, the pairing of the two write ports with adjacent indices, the all-lanes override and the load-mask choice, the sign bits under each modifier combination, the zero high half of narrow results, and scalar broadcast uniformity. The bench alone can show that data actually reaches the right lane and half. It drives writes through a register file model and reads the registers back. The same method covers three other behaviours: that masked-off lanes keep both halves, that the live wavefront mask governs non-load writes, and that the bits other than the sign bit survive each modifier.

// File: rtl/vop_pkg.sv
package vop_pkg;

    localparam int ELEM_W = 32;
    localparam int PAIR_W = 2 * ELEM_W;

    typedef struct packed {
        logic from_vec;
        logic wide;
        logic abs_m;
        logic neg_m;
    } src_ctl_t;

    typedef enum logic [1:0] {
        MSRC_WAVE = 2'd0,
        MSRC_INST = 2'd1,
        MSRC_ALL  = 2'd2
    } mask_src_e;

    function automatic mask_src_e choose_mask(input logic ignore_exec, input logic is_load);
        if (ignore_exec)
            return MSRC_ALL;
        else if (is_load)
            return MSRC_INST;
        else
            return MSRC_WAVE;
    endfunction

    // Bitwise sign handling: abs clears, negate inverts afterwards.
    function automatic logic [PAIR_W-1:0] apply_sign_mods(
        input logic [PAIR_W-1:0] v,
        input logic              wide,
        input logic              abs_m,
        input logic              neg_m
    );
        logic [PAIR_W-1:0] r;
        r = v;
        if (wide) begin
            if (abs_m) r[PAIR_W-1] = 1'b0;
            if (neg_m) r[PAIR_W-1] = ~r[PAIR_W-1];
        end else begin
            if (abs_m) r[ELEM_W-1] = 1'b0;
            if (neg_m) r[ELEM_W-1] = ~r[ELEM_W-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/vop_lane_join.sv
module vop_lane_join
    import vop_pkg::*;
(
    input  logic [ELEM_W-1:0] lo_word,
    input  logic [ELEM_W-1:0] hi_word,
    input  logic [PAIR_W-1:0] scalar_val,
    input  src_ctl_t          ctl,
    output logic [PAIR_W-1:0] lane_val
);

    logic [PAIR_W-1:0] raw;

    always_comb begin
        if (ctl.from_vec) begin
            raw = ctl.wide ? {hi_word, lo_word} : {{ELEM_W{1'b0}}, lo_word};
        end else begin
            raw = ctl.wide ? scalar_val : {{ELEM_W{1'b0}}, scalar_val[ELEM_W-1:0]};
        end
        lane_val = apply_sign_mods(raw, ctl.wide, ctl.abs_m, ctl.neg_m);
    end

endmodule

// File: rtl/vop_read_path.sv
module vop_read_path
    import vop_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IDX_W = 8,
    localparam int REG_W = LANES * ELEM_W,
    localparam int RES_W = LANES * PAIR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  src_ctl_t          rd_ctl,
    input  logic [IDX_W-1:0]  rd_base,
    input  logic [PAIR_W-1:0] rd_scalar,
    output logic              rf_rd_en0,
    output logic              rf_rd_en1,
    output logic [IDX_W-1:0]  rf_rd_addr0,
    output logic [IDX_W-1:0]  rf_rd_addr1,
    input  logic [REG_W-1:0]  rf_rd_data0,
    input  logic [REG_W-1:0]  rf_rd_data1,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data
);

    logic              s1_valid;
    src_ctl_t          s1_ctl;
    logic [PAIR_W-1:0] s1_scalar;
    src_ctl_t          s2_ctl;
    logic [RES_W-1:0]  joined;

    assign rf_rd_en0   = rd_valid && rd_ctl.from_vec;
    assign rf_rd_en1   = rd_valid && rd_ctl.from_vec && rd_ctl.wide;
    assign rf_rd_addr0 = rd_base;
    assign rf_rd_addr1 = IDX_W'(rd_base + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_ctl    <= '0;
            s1_scalar <= '0;
        end else begin
            s1_valid <= rd_valid;
            if (rd_valid) begin
                s1_ctl    <= rd_ctl;
                s1_scalar <= rd_scalar;
            end
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        vop_lane_join u_join (
            .lo_word    (rf_rd_data0[ln*ELEM_W +: ELEM_W]),
            .hi_word    (rf_rd_data1[ln*ELEM_W +: ELEM_W]),
            .scalar_val (s1_scalar),
            .ctl        (s1_ctl),
            .lane_val   (joined[ln*PAIR_W +: PAIR_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            s2_ctl    <= '0;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                res_data <= joined;
                s2_ctl   <= s1_ctl;
            end
        end
    end

    // Observation vectors for the checks below.
    logic [LANES-1:0] sign_bits;
    logic [LANES-1:0] hi_nonzero;
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            sign_bits[k]  = s2_ctl.wide ? res_data[k*PAIR_W + PAIR_W - 1]
                                        : res_data[k*PAIR_W + ELEM_W - 1];
            hi_nonzero[k] = |res_data[k*PAIR_W + ELEM_W +: ELEM_W];
        end
    end

    AST_RD_STAGE1: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> s1_valid);                                             // R2
    AST_RD_STAGE2: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> res_valid);                                            // R2
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !res_valid);                                          // R2
    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !s2_ctl.wide) |-> (hi_nonzero == '0));                // R2
    AST_ABS_SIGN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (res_valid && s2_ctl.abs_m && !s2_ctl.neg_m) |-> (sign_bits == '0)); // R5
    AST_NEG_ABS_SIGN_SET: assert property (@(posedge clk) disable iff (rst)
        (res_valid && s2_ctl.abs_m && s2_ctl.neg_m) |-> (&sign_bits));      // R6
    AST_SCALAR_BCAST: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !s2_ctl.from_vec) |->
        (res_data[0 +: PAIR_W] == res_data[(LANES-1)*PAIR_W +: PAIR_W]));   // R4

endmodule

// File: rtl/vop_mask_sel.sv
module vop_mask_sel
    import vop_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             ignore_exec,
    input  logic             is_load,
    input  logic [LANES-1:0] inst_mask,
    input  logic [LANES-1:0] wave_mask,
    output logic [LANES-1:0] lane_en
);

    mask_src_e src;

    always_comb begin
        src = choose_mask(ignore_exec, is_load);
        unique case (src)
            MSRC_ALL:  lane_en = '1;
            MSRC_INST: lane_en = inst_mask;
            default:   lane_en = wave_mask;
        endcase
    end

endmodule

// File: rtl/vop_write_path.sv
module vop_write_path
    import vop_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IDX_W = 8,
    localparam int REG_W = LANES * ELEM_W,
    localparam int RES_W = LANES * PAIR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic             wr_wide,
    input  logic             wr_is_load,
    input  logic             wr_ignore_exec,
    input  logic [IDX_W-1:0] wr_base,
    input  logic [LANES-1:0] wr_inst_mask,
    input  logic [LANES-1:0] wave_exec_mask,
    input  logic [RES_W-1:0] wr_data,
    output logic             rf_wr_en0,
    output logic             rf_wr_en1,
    output logic [IDX_W-1:0] rf_wr_addr0,
    output logic [IDX_W-1:0] rf_wr_addr1,
    output logic [LANES-1:0] rf_wr_lane_en,
    output logic [REG_W-1:0] rf_wr_data0,
    output logic [REG_W-1:0] rf_wr_data1
);

    logic [LANES-1:0] lane_en_d;
    logic [REG_W-1:0] lo_d;
    logic [REG_W-1:0] hi_d;

    vop_mask_sel #(.LANES(LANES)) u_mask (
        .ignore_exec (wr_ignore_exec),
        .is_load     (wr_is_load),
        .inst_mask   (wr_inst_mask),
        .wave_mask   (wave_exec_mask),
        .lane_en     (lane_en_d)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_split
        assign lo_d[ln*ELEM_W +: ELEM_W] = wr_data[ln*PAIR_W +: ELEM_W];
        assign hi_d[ln*ELEM_W +: ELEM_W] = wr_data[ln*PAIR_W + ELEM_W +: ELEM_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_wr_en0     <= 1'b0;
            rf_wr_en1     <= 1'b0;
            rf_wr_addr0   <= '0;
            rf_wr_addr1   <= '0;
            rf_wr_lane_en <= '0;
            rf_wr_data0   <= '0;
            rf_wr_data1   <= '0;
        end else begin
            rf_wr_en0 <= wr_valid;
            rf_wr_en1 <= wr_valid && wr_wide;
            if (wr_valid) begin
                rf_wr_addr0   <= wr_base;
                rf_wr_addr1   <= IDX_W'(wr_base + 1'b1);
                rf_wr_lane_en <= lane_en_d;
                rf_wr_data0   <= lo_d;
                rf_wr_data1   <= hi_d;
            end
        end
    end

    AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> rf_wr_en0);                                            // R8
    AST_WR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (!rf_wr_en0 && !rf_wr_en1));                          // R8
    AST_WIDE_PAIR: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en1 |-> (rf_wr_en0 && rf_wr_addr1 == IDX_W'(rf_wr_addr0 + 1'b1))); // R9
    AST_IGNORE_ALL: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ignore_exec) |=> (&rf_wr_lane_en));                 // R11
    AST_LOAD_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ignore_exec && wr_is_load) |=>
        (rf_wr_lane_en == $past(wr_inst_mask)));                            // R10

endmodule

// File: rtl/vop_access_unit.sv
module vop_access_unit
    import vop_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_valid,
    input  logic                      rd_from_vec,
    input  logic                      rd_wide,
    input  logic                      rd_abs,
    input  logic                      rd_neg,
    input  logic [IDX_W-1:0]          rd_base,
    input  logic [63:0]               rd_scalar,
    output logic                      rf_rd_en0,
    output logic                      rf_rd_en1,
    output logic [IDX_W-1:0]          rf_rd_addr0,
    output logic [IDX_W-1:0]          rf_rd_addr1,
    input  logic [LANES*32-1:0]       rf_rd_data0,
    input  logic [LANES*32-1:0]       rf_rd_data1,
    output logic                      res_valid,
    output logic [LANES*64-1:0]       res_data,
    input  logic                      wr_valid,
    input  logic                      wr_wide,
    input  logic                      wr_is_load,
    input  logic                      wr_ignore_exec,
    input  logic [IDX_W-1:0]          wr_base,
    input  logic [LANES-1:0]          wr_inst_mask,
    input  logic [LANES-1:0]          wave_exec_mask,
    input  logic [LANES*64-1:0]       wr_data,
    output logic                      rf_wr_en0,
    output logic                      rf_wr_en1,
    output logic [IDX_W-1:0]          rf_wr_addr0,
    output logic [IDX_W-1:0]          rf_wr_addr1,
    output logic [LANES-1:0]          rf_wr_lane_en,
    output logic [LANES*32-1:0]       rf_wr_data0,
    output logic [LANES*32-1:0]       rf_wr_data1
);

    src_ctl_t rd_ctl;

    always_comb begin
        rd_ctl.from_vec = rd_from_vec;
        rd_ctl.wide     = rd_wide;
        rd_ctl.abs_m    = rd_abs;
        rd_ctl.neg_m    = rd_neg;
    end

    vop_read_path #(.LANES(LANES), .IDX_W(IDX_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_valid    (rd_valid),
        .rd_ctl      (rd_ctl),
        .rd_base     (rd_base),
        .rd_scalar   (rd_scalar),
        .rf_rd_en0   (rf_rd_en0),
        .rf_rd_en1   (rf_rd_en1),
        .rf_rd_addr0 (rf_rd_addr0),
        .rf_rd_addr1 (rf_rd_addr1),
        .rf_rd_data0 (rf_rd_data0),
        .rf_rd_data1 (rf_rd_data1),
        .res_valid   (res_valid),
        .res_data    (res_data)
    );

    vop_write_path #(.LANES(LANES), .IDX_W(IDX_W)) u_wr (
        .clk            (clk),
        .rst            (rst),
        .wr_valid       (wr_valid),
        .wr_wide        (wr_wide),
        .wr_is_load     (wr_is_load),
        .wr_ignore_exec (wr_ignore_exec),
        .wr_base        (wr_base),
        .wr_inst_mask   (wr_inst_mask),
        .wave_exec_mask (wave_exec_mask),
        .wr_data        (wr_data),
        .rf_wr_en0      (rf_wr_en0),
        .rf_wr_en1      (rf_wr_en1),
        .rf_wr_addr0    (rf_wr_addr0),
        .rf_wr_addr1    (rf_wr_addr1),
        .rf_wr_lane_en  (rf_wr_lane_en),
        .rf_wr_data0    (rf_wr_data0),
        .rf_wr_data1    (rf_wr_data1)
    );

endmodule

// File: tb/vop_access_unit_tb_top.sv
module vop_access_unit_tb_top;

    localparam int L     = 64;
    localparam int IW    = 8;
    localparam int NREG  = 16;
    localparam int RW    = L * 32;
    localparam int VW    = L * 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_valid, rd_from_vec, rd_wide, rd_abs, rd_neg;
    logic [IW-1:0] rd_base;
    logic [63:0]   rd_scalar;
    logic          rf_rd_en0, rf_rd_en1;
    logic [IW-1:0] rf_rd_addr0, rf_rd_addr1;
    logic [RW-1:0] rf_rd_data0, rf_rd_data1;
    logic          res_valid;
    logic [VW-1:0] res_data;
    logic          wr_valid, wr_wide, wr_is_load, wr_ignore_exec;
    logic [IW-1:0] wr_base;
    logic [L-1:0]  wr_inst_mask, wave_exec_mask;
    logic [VW-1:0] wr_data;
    logic          rf_wr_en0, rf_wr_en1;
    logic [IW-1:0] rf_wr_addr0, rf_wr_addr1;
    logic [L-1:0]  rf_wr_lane_en;
    logic [RW-1:0] rf_wr_data0, rf_wr_data1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    vop_access_unit #(.LANES(L), .IDX_W(IW)) dut_i (.*);

    // Register file model: synchronous read, lane-enabled write.
    logic [RW-1:0] rf_mem [NREG];
    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) rf_mem[r] <= '0;
            rf_rd_data0 <= '0;
            rf_rd_data1 <= '0;
        end else begin
            if (rf_rd_en0) rf_rd_data0 <= rf_mem[rf_rd_addr0[3:0]];
            if (rf_rd_en1) rf_rd_data1 <= rf_mem[rf_rd_addr1[3:0]];
            for (int ln = 0; ln < L; ln++) begin
                if (rf_wr_en0 && rf_wr_lane_en[ln])
                    rf_mem[rf_wr_addr0[3:0]][ln*32 +: 32] <= rf_wr_data0[ln*32 +: 32];
                if (rf_wr_en1 && rf_wr_lane_en[ln])
                    rf_mem[rf_wr_addr1[3:0]][ln*32 +: 32] <= rf_wr_data1[ln*32 +: 32];
            end
        end
    end

    // Shadow of expected register contents, kept from the requirements.
    logic [RW-1:0] exp_mem [NREG];
    logic [VW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int seed, input int ln, input int half);
        return 32'(seed * 32'h0100_0193) ^ 32'(ln * 32'h9E37_79B1) ^ 32'(half * 32'hC5A3_3B17);
    endfunction

    function automatic logic [63:0] mods(input logic [63:0] v, input bit wide,
                                         input bit a, input bit n);
        int sb;
        logic [63:0] r;
        sb = wide ? 63 : 31;
        r = v;
        if (a) r[sb] = 1'b0;
        if (n) r[sb] = ~r[sb];
        return r;
    endfunction

    // Monitor: compare each produced result with the oldest expected item.
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", 128'(res_data[63:0]), 128'd0);
            end else begin
                logic [VW-1:0] e;
                string t;
                int bad;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                bad = -1;
                for (int ln = L - 1; ln >= 0; ln--)
                    if (res_data[ln*64 +: 64] !== e[ln*64 +: 64]) bad = ln;
                if (bad < 0) check(1'b1, t, '0, '0);
                else check(1'b0, $sformatf("%s lane %0d", t, bad),
                           128'(res_data[bad*64 +: 64]), 128'(e[bad*64 +: 64]));
            end
        end
    end

    task automatic do_read(input int base, input bit wide, input bit vec, input bit a,
                           input bit n, input logic [63:0] sc, input string tag);
        logic [VW-1:0] e;
        for (int ln = 0; ln < L; ln++) begin
            logic [63:0] v;
            if (vec) v = wide ? {exp_mem[base+1][ln*32 +: 32], exp_mem[base][ln*32 +: 32]}
                              : {32'd0, exp_mem[base][ln*32 +: 32]};
            else     v = wide ? sc : {32'd0, sc[31:0]};
            e[ln*64 +: 64] = mods(v, wide, a, n);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_valid = 1'b1; rd_from_vec = vec; rd_wide = wide; rd_abs = a; rd_neg = n;
        rd_base = IW'(base); rd_scalar = sc;
        #1;
        if (vec) begin
            check(rf_rd_en0 && rf_rd_addr0 == IW'(base), "R2 read index low",
                  128'(rf_rd_addr0), 128'(base));
            if (wide)
                check(rf_rd_en1 && rf_rd_addr1 == IW'(base + 1), "R3 read index high",
                      128'(rf_rd_addr1), 128'(base + 1));
        end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic do_write(input int base, input bit wide, input bit ld, input bit ign,
                            input logic [L-1:0] im, input logic [L-1:0] wm,
                            input int seed, input string tag);
        logic [L-1:0] en;
        en = ign ? '1 : (ld ? im : wm);
        for (int ln = 0; ln < L; ln++) begin
            wr_data[ln*64 +: 32]      = pat(seed, ln, 0);
            wr_data[ln*64 + 32 +: 32] = pat(seed, ln, 1);
            if (en[ln]) begin
                exp_mem[base][ln*32 +: 32] = pat(seed, ln, 0);
                if (wide) exp_mem[base+1][ln*32 +: 32] = pat(seed, ln, 1);
            end
        end
        wr_valid = 1'b1; wr_wide = wide; wr_is_load = ld; wr_ignore_exec = ign;
        wr_base = IW'(base); wr_inst_mask = im; wave_exec_mask = wm;
        @(negedge clk);
        wr_valid = 1'b0;
        check(rf_wr_en0 && rf_wr_addr0 == IW'(base), {tag, " R8 port0 enable/index"},
              128'({rf_wr_en0, rf_wr_addr0}), 128'({1'b1, IW'(base)}));
        check(rf_wr_en1 == wide, {tag, " R9 port1 enable"}, 128'(rf_wr_en1), 128'(wide));
        check(rf_wr_lane_en == en, {tag, " R10/R11 lane enables"},
              128'(rf_wr_lane_en), 128'(en));
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) exp_mem[r] = '0;
        rst = 1'b1;
        rd_valid = 0; rd_from_vec = 0; rd_wide = 0; rd_abs = 0; rd_neg = 0;
        rd_base = '0; rd_scalar = '0;
        wr_valid = 0; wr_wide = 0; wr_is_load = 0; wr_ignore_exec = 0;
        wr_base = '0; wr_inst_mask = '0; wave_exec_mask = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check(!res_valid && !rf_wr_en0 && !rf_wr_en1, "R1 reset outputs idle",
              128'({res_valid, rf_wr_en0, rf_wr_en1}), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!res_valid && !rf_wr_en0 && !rf_wr_en1, "R1 first cycle after reset",
              128'({res_valid, rf_wr_en0, rf_wr_en1}), 128'd0);

        // Full wide write then readback.
        do_write(2, 1, 0, 0, '0, '1, 11, "R9 wide full");
        do_read(2, 1, 1, 0, 0, 64'd0, "R3 wide readback");
        // Narrow write gated by the live mask; instruction mask must be ignored.
        do_write(5, 0, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'hF0F0_F0F0_F0F0_F0F0, 22, "R10 wave mask");
        do_read(5, 0, 1, 0, 0, 64'd0, "R12 narrow partial readback");
        // Load write uses the captured mask.
        do_write(5, 0, 1, 0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 33, "R10 load mask");
        do_read(5, 0, 1, 0, 0, 64'd0, "R10 load readback");
        // Override enables all lanes with empty masks.
        do_write(8, 1, 1, 1, '0, '0, 44, "R11 ignore exec");
        do_read(8, 1, 1, 0, 0, 64'd0, "R11 readback");
        // Partial wide overwrite keeps both halves of disabled lanes.
        do_write(2, 1, 0, 0, '0, 64'hAAAA_5555_0000_FFFF, 55, "R12 wide partial");
        do_read(2, 1, 1, 0, 0, 64'd0, "R12 wide halves kept");
        do_read(3, 0, 1, 0, 0, 64'd0, "R12 high register narrow view");
        // Modifiers, issued back to back.
        do_read(2, 1, 1, 1, 0, 64'd0, "R5 abs wide");
        do_read(5, 0, 1, 1, 0, 64'd0, "R5 abs narrow");
        do_read(8, 1, 1, 0, 1, 64'd0, "R6 neg wide");
        do_read(5, 0, 1, 0, 1, 64'd0, "R6 neg narrow");
        do_read(2, 1, 1, 1, 1, 64'd0, "R6 abs+neg wide");
        // Scalar broadcast.
        do_read(2, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, "R4 scalar narrow");
        do_read(2, 1, 0, 0, 0, 64'h8000_0000_0000_0001, "R4 scalar wide");
        do_read(0, 1, 0, 1, 0, 64'hBFF0_0000_0000_0000, "R7 scalar abs wide");
        do_read(0, 0, 0, 0, 1, 64'h0000_0000_3F80_0000, "R7 scalar neg narrow");
        do_read(0, 1, 0, 1, 1, 64'h4000_0000_0000_0000, "R7 scalar abs+neg");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results delivered", 128'(exp_q.size()), 128'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule